// File: doc/BRIEF.md
# Prioritized DMA Bus Arbiter

This block decides who owns a shared peripheral bus. The requesters are one CPU master and a parameterized number of DMA channels. Each channel brings a request line, a 3-bit priority level and a round-robin enable. The block registers its decision as a one-hot channel grant or a CPU grant. It keeps that grant until the current owner strobes transaction-done. On that strobe it arbitrates again in the same cycle, so a more urgent requester can take the bus only at a transaction boundary. A bus with no owner is arbitrated every cycle.

The CPU always wins. Among the DMA channels the smallest level number wins. When the global fairness enable is set, each of levels 2 to 7 has a programmable quota. The quota is a number of DMA grants that the level should receive within a window of 64 DMA grants. A level that has not yet met its quota is ranked above the levels 2 to 7 that have met theirs. Levels 0 and 1 are never demoted, so they can use the whole bus. Ties inside a level are settled in two steps. First, channels with round robin switched off go ahead of the others, lowest index first. Otherwise the grant rotates among the requesting channels.

Top module: `dma_bus_arbiter`

## Requirements
- R1: Out of reset both grants are zero. At most one of cpu_gnt and the dma_gnt bits is high at a time. An arbitration with no request pending leaves every grant low.
- R2: A registered grant stays unchanged while xfer_done is low. Arbitration happens on a cycle with xfer_done high or when no grant is held, and the result appears after the next rising edge. xfer_done while idle has no other effect.
- R3: At every arbitration, a pending cpu_req is granted ahead of any DMA request.
- R4: With fair_en low, the requesting channel with the numerically smallest level wins. Channel i's level is dma_prio[3*i+:3].
- R5: A request at a better level that arrives while another channel owns the bus does not change the grant until xfer_done. At that arbitration it wins.
- R6: With fair_en high, a level L in 2..7 whose grant count in the current window is below its quota outranks every level in 2..7 that has met its quota. Levels of equal standing are ordered by number. The quota for L is lvl_quota[6*(L-2)+:6].
- R7: Levels 0 and 1 always outrank levels 2..7, whatever the quota state.
- R8: Each DMA grant adds one to the count of its level. The 64th DMA grant of a window starts a new window and clears every level count, including its own.
- R9: Among requesting channels at the winning level that have rr_en set, the grant goes to the first one above the last rr_en channel granted at that level, wrapping around. The first search at each level starts at channel 0.
- R10: A requesting channel at the winning level with rr_en low is granted before any rr_en channel at that level. Among several such channels the lowest index wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | CPU bus request |
| dma_req | input | N_CH | Per-channel DMA request |
| dma_prio | input | 3*N_CH | Per-channel level, 0 is most urgent |
| rr_en | input | N_CH | Per-channel round-robin enable |
| fair_en | input | 1 | Global fairness enable |
| lvl_quota | input | 6*QW | Window quota for levels 2..7 |
| xfer_done | input | 1 | Owner finished its transaction |
| cpu_gnt | output | 1 | Registered CPU grant |
| dma_gnt | output | N_CH | Registered one-hot DMA grant |

## Verification
Directed sequences each isolate one rule:
- A CPU request contending with DMA requests.
- Request changes while xfer_done is held low, which separates holding the grant from re-arbitration.
- An urgent level arriving mid-transfer, which shows that preemption waits for the transaction boundary.
- Several channels at one level with rr_en set and with it clear, which separates rotation from the fixed order.
- A long fairness run with one starved low level against a level whose quota is already met. It shows promotion, demotion once the quota is met, and the clear after 64 grants.

Random requests, levels, quotas, done strobes and fairness settings then mix all of these rules against a reference model kept in the bench.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
   localparam int LVL_W    = 3;
   localparam int NUM_LVL  = 1 << LVL_W;
   localparam int FIRST_FAIR_LVL = 2;
   localparam int NUM_FAIR = NUM_LVL - FIRST_FAIR_LVL;

   typedef logic [LVL_W-1:0] lvl_t;
   typedef logic [LVL_W:0]   rank_t;

   function automatic rank_t make_rank(input lvl_t lvl, input logic fair_on,
                                       input logic met);
      logic demote;
      demote = fair_on && (lvl >= lvl_t'(FIRST_FAIR_LVL)) && met;
      return {demote, lvl};
   endfunction
endpackage

// File: rtl/dma_arb_quota.sv
module dma_arb_quota
   import dma_arb_pkg::*;
#(
   parameter int QW     = 6,
   parameter int WINDOW = 64
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   upd,
   input  lvl_t                   upd_lvl,
   input  logic [NUM_FAIR*QW-1:0] quota,
   output logic [NUM_LVL-1:0]     met
);
   localparam int CNTW = $clog2(WINDOW);

   logic [CNTW-1:0] win_q;
   logic            wrap;

   assign wrap = (win_q == CNTW'(WINDOW-1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         win_q <= '0;
      else if (upd)
         win_q <= wrap ? '0 : win_q + 1'b1;
   end

   generate
      for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
         if (l < FIRST_FAIR_LVL) begin : g_exempt
            assign met[l] = 1'b0;
         end else begin : g_fair
            logic [CNTW-1:0] cnt_q;
            logic [QW-1:0]   q_l;
            assign q_l = quota[(l-FIRST_FAIR_LVL)*QW +: QW];
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)
                  cnt_q <= '0;
               else if (upd) begin
                  if (wrap)
                     cnt_q <= '0;
                  else if (upd_lvl == lvl_t'(l))
                     cnt_q <= cnt_q + 1'b1;
               end
            end
            assign met[l] = ({{(QW+1){1'b0}}, cnt_q} >= {{(CNTW+1){1'b0}}, q_l});

            AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
               cnt_q <= win_q); // R8
         end
      end
   endgenerate

   AST_WIN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && wrap) |=> (win_q == '0)); // R8
endmodule

// File: rtl/dma_arb_pick.sv
module dma_arb_pick
   import dma_arb_pkg::*;
#(
   parameter int N_CH = 8,
   localparam int CW  = $clog2(N_CH)
) (
   input  logic [N_CH-1:0]       req,
   input  logic [LVL_W*N_CH-1:0] prio,
   input  logic [N_CH-1:0]       rr_en,
   input  logic                  fair_on,
   input  logic [NUM_LVL-1:0]    met,
   input  logic [NUM_LVL*CW-1:0] last,
   output logic                  any,
   output logic [CW-1:0]         idx,
   output lvl_t                  lvl,
   output logic                  via_rr
);
   rank_t rank [N_CH];

   generate
      for (genvar i = 0; i < N_CH; i++) begin : g_rank
         lvl_t li;
         assign li      = prio[i*LVL_W +: LVL_W];
         assign rank[i] = make_rank(li, fair_on, met[li]);
      end
   endgenerate

   rank_t           best;
   logic            fix_found, rr_found;
   logic [CW-1:0]   fix_idx, rr_idx, ptr;

   always_comb begin
      best = '0;
      any  = 1'b0;
      for (int i = 0; i < N_CH; i++)
         if (req[i] && (!any || rank[i] < best)) begin
            best = rank[i];
            any  = 1'b1;
         end
      lvl = best[LVL_W-1:0];

      fix_found = 1'b0;
      fix_idx   = '0;
      for (int i = 0; i < N_CH; i++)
         if (!fix_found && req[i] && !rr_en[i] && rank[i] == best) begin
            fix_found = 1'b1;
            fix_idx   = CW'(i);
         end

      ptr      = last[lvl*CW +: CW];
      rr_found = 1'b0;
      rr_idx   = '0;
      for (int off = 1; off <= N_CH; off++) begin
         int j;
         j = (int'(ptr) + off) % N_CH;
         if (!rr_found && req[j] && rr_en[j] && rank[j] == best) begin
            rr_found = 1'b1;
            rr_idx   = CW'(j);
         end
      end

      via_rr = !fix_found;
      idx    = fix_found ? fix_idx : rr_idx;
   end
endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter
   import dma_arb_pkg::*;
#(
   parameter int N_CH   = 8,
   parameter int QW     = 6,
   parameter int WINDOW = 64
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cpu_req,
   input  logic [N_CH-1:0]        dma_req,
   input  logic [LVL_W*N_CH-1:0]  dma_prio,
   input  logic [N_CH-1:0]        rr_en,
   input  logic                   fair_en,
   input  logic [NUM_FAIR*QW-1:0] lvl_quota,
   input  logic                   xfer_done,
   output logic                   cpu_gnt,
   output logic [N_CH-1:0]        dma_gnt
);
   localparam int CW = $clog2(N_CH);

   if (N_CH < 2 || (1 << CW) != N_CH)
      $error("N_CH must be a power of two of at least 2");
   if (WINDOW < 2 || (1 << $clog2(WINDOW)) != WINDOW)
      $error("WINDOW must be a power of two of at least 2");
   if (QW < 1 || (1 << QW) < WINDOW)
      $error("QW must be able to express a full window");

   logic                  cpu_q;
   logic [N_CH-1:0]       gnt_q;
   logic                  busy, decide, any, via_rr, upd;
   logic [CW-1:0]         idx;
   lvl_t                  win_lvl;
   logic [NUM_LVL-1:0]    met;
   logic [NUM_LVL*CW-1:0] last_q;

   assign busy   = cpu_q || (|gnt_q);
   assign decide = !busy || xfer_done;
   assign upd    = decide && !cpu_req && any;

   dma_arb_pick #(.N_CH(N_CH)) pick_i (
      .req(dma_req), .prio(dma_prio), .rr_en(rr_en), .fair_on(fair_en),
      .met(met), .last(last_q), .any(any), .idx(idx), .lvl(win_lvl),
      .via_rr(via_rr)
   );

   dma_arb_quota #(.QW(QW), .WINDOW(WINDOW)) quota_i (
      .clk(clk), .rst_n(rst_n), .upd(upd), .upd_lvl(win_lvl),
      .quota(lvl_quota), .met(met)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cpu_q <= 1'b0;
         gnt_q <= '0;
      end else if (decide) begin
         cpu_q <= cpu_req;
         gnt_q <= upd ? (N_CH'(1) << idx) : '0;
      end
   end

   generate
      for (genvar l = 0; l < NUM_LVL; l++) begin : g_ptr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               last_q[l*CW +: CW] <= CW'(N_CH-1);
            else if (upd && via_rr && win_lvl == lvl_t'(l))
               last_q[l*CW +: CW] <= idx;
         end
      end
   endgenerate

   assign cpu_gnt = cpu_q;
   assign dma_gnt = gnt_q;

   AST_GNT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dma_gnt) && !(cpu_gnt && (|dma_gnt))); // R1
   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (decide && !cpu_req && !(|dma_req)) |=> (!cpu_gnt && dma_gnt == '0)); // R1
   AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !xfer_done) |=> ($stable(dma_gnt) && $stable(cpu_gnt))); // R2
   AST_CPU_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (decide && cpu_req) |=> cpu_gnt); // R3
   AST_GNT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (decide && !cpu_req && (|dma_req)) |=> ((dma_gnt & $past(dma_req)) != '0)); // R4
endmodule

// File: tb/dma_bus_arbiter_tb.sv
module dma_bus_arbiter_tb_top;
   localparam int N  = 8;
   localparam int QW = 6;
   localparam int WIN = 64;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cpu_req = 1'b0;
   logic [N-1:0] dma_req = '0;
   logic [3*N-1:0] dma_prio = '0;
   logic [N-1:0] rr_en = '0;
   logic fair_en = 1'b0;
   logic [6*QW-1:0] lvl_quota = '0;
   logic xfer_done = 1'b0;
   logic cpu_gnt;
   logic [N-1:0] dma_gnt;

   int n_chk = 0, n_bad = 0;

   // model state
   int m_cnt [8];
   int m_win;
   int m_last [8];
   int m_g;
   bit m_c;

   always #10 clk = ~clk;

   dma_bus_arbiter #(.N_CH(N), .QW(QW), .WINDOW(WIN)) dut_i (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .dma_req(dma_req),
      .dma_prio(dma_prio), .rr_en(rr_en), .fair_en(fair_en),
      .lvl_quota(lvl_quota), .xfer_done(xfer_done),
      .cpu_gnt(cpu_gnt), .dma_gnt(dma_gnt)
   );

   function automatic int lvl_of(int ch);
      return int'(dma_prio[3*ch +: 3]);
   endfunction

   function automatic int rank_of(int ch);
      int l;
      l = lvl_of(ch);
      if (fair_en && l >= 2 && m_cnt[l] >= int'(lvl_quota[6*(l-2) +: 6]))
         return 8 + l;
      return l;
   endfunction

   function automatic int pick(output bit rr);
      int best, res;
      best = 99; res = -1; rr = 0;
      for (int i = 0; i < N; i++)
         if (dma_req[i] && rank_of(i) < best) best = rank_of(i);
      if (best == 99) return -1;
      for (int i = 0; i < N; i++)
         if (res < 0 && dma_req[i] && !rr_en[i] && rank_of(i) == best) res = i;
      if (res >= 0) return res;
      rr = 1;
      for (int off = 1; off <= N; off++) begin
         int j;
         j = (m_last[best % 8] + off) % N;
         if (res < 0 && dma_req[j] && rr_en[j] && rank_of(j) == best) res = j;
      end
      return res;
   endfunction

   task automatic model_reset();
      for (int l = 0; l < 8; l++) begin m_cnt[l] = 0; m_last[l] = N-1; end
      m_win = 0; m_g = -1; m_c = 0;
   endtask

   task automatic model_step();
      bit rr;
      int p, l;
      if (!(m_c || m_g >= 0) || xfer_done) begin
         p = pick(rr);
         m_c = cpu_req;
         m_g = -1;
         if (!cpu_req && p >= 0) begin
            m_g = p;
            l = lvl_of(p);
            if (rr) m_last[l] = p;
            if (m_win == WIN-1) begin
               m_win = 0;
               for (int k = 0; k < 8; k++) m_cnt[k] = 0;
            end else begin
               m_win++;
               m_cnt[l]++;
            end
         end
      end
   endtask

   task automatic check(string tag);
      logic [N-1:0] exp_g;
      exp_g = (m_g >= 0) ? (N'(1) << m_g) : '0;
      n_chk++;
      if (dma_gnt !== exp_g || cpu_gnt !== m_c) begin
         n_bad++;
         $display("FAIL %s: got cpu=%b dma=%b expected cpu=%b dma=%b",
                  tag, cpu_gnt, dma_gnt, m_c, exp_g);
      end
   endtask

   // inputs change at negedge only; model advances at posedge
   task automatic step(string tag);
      @(posedge clk);
      model_step();
      @(negedge clk);
      check(tag);
   endtask

   task automatic set_ch(int ch, bit rq, int lvl, bit rr);
      dma_req[ch] = rq;
      dma_prio[3*ch +: 3] = 3'(lvl);
      rr_en[ch] = rr;
   endtask

   task automatic set_quota(int lvl, int q);
      lvl_quota[6*(lvl-2) +: 6] = 6'(q);
   endtask

   task automatic idle_all();
      cpu_req = 0; dma_req = '0; xfer_done = 1;
      step("R1 drain");
      step("R1 drain");
   endtask

   initial begin
      #3000000;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(1234));
      model_reset();
      repeat (3) @(negedge clk);
      check("R1 reset");
      rst_n = 1;
      @(negedge clk);

      // R3: CPU beats DMA
      set_ch(2, 1, 0, 1); cpu_req = 1; xfer_done = 1;
      step("R3 cpu first");
      cpu_req = 0;
      step("R3 dma after cpu");
      // R2: hold without done, requests changing
      xfer_done = 0; set_ch(2, 0, 0, 1); set_ch(5, 1, 0, 1); cpu_req = 1;
      step("R2 hold");
      step("R2 hold");
      idle_all();
      xfer_done = 1;
      step("R1 idle zero");
      step("R2 done while idle");

      // R5: preemption at boundary only
      xfer_done = 0;
      set_ch(3, 1, 5, 1);
      step("R5 low level owns");
      set_ch(1, 1, 1, 1);
      step("R5 no mid preempt");
      step("R5 no mid preempt");
      xfer_done = 1;
      step("R5 preempt at done");
      idle_all();

      // R4: strict by level, fairness off
      fair_en = 0;
      set_ch(0, 1, 6, 0); set_ch(4, 1, 2, 0); set_ch(7, 1, 4, 0);
      step("R4 lowest level");
      step("R4 lowest level");
      set_ch(4, 0, 2, 0);
      step("R4 next level");
      idle_all();

      // R9: rotation at one level
      set_ch(2, 1, 3, 1); set_ch(4, 1, 3, 1); set_ch(6, 1, 3, 1);
      for (int k = 0; k < 5; k++) step("R9 rotate");
      // R10: fixed-order channels go first, lowest index
      set_ch(5, 1, 3, 0); set_ch(7, 1, 3, 0);
      for (int k = 0; k < 3; k++) step("R10 fixed first");
      idle_all();
      for (int c = 0; c < N; c++) set_ch(c, 0, 0, 1);

      // R6/R7/R8: fairness
      fair_en = 1;
      for (int l = 2; l < 8; l++) set_quota(l, 0);
      set_quota(6, 3);
      set_ch(1, 1, 2, 1); set_ch(3, 1, 6, 1);
      for (int k = 0; k < 70; k++) step("R6 R8 quota window");
      set_ch(0, 1, 1, 1);
      for (int k = 0; k < 4; k++) step("R7 exempt level wins");
      idle_all();

      // random mix
      for (int k = 0; k < 4000; k++) begin
         cpu_req   = ($urandom % 6) == 0;
         xfer_done = ($urandom % 3) != 0;
         if ((k % 200) == 0) begin
            fair_en = $urandom;
            for (int l = 2; l < 8; l++) set_quota(l, $urandom % 12);
         end
         for (int c = 0; c < N; c++)
            set_ch(c, ($urandom % 3) == 0, $urandom % 8, ($urandom % 4) != 0);
         step("R4 R6 R8 R9 R10 random");
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule